// File: doc/BRIEF.md
# Key-Protected System Control Register Block

This block is a bank of 32-bit control and status registers on a simple word-addressed bus with separate read and write strobes. It comes out of reset locked. While it is locked, software can change only a one-bit scratch control and the two key registers. Writing the unlock key opens the other writable registers. Writing the lock key closes them again. Every offset has a fixed access direction: read-write, read-only, write-only or unmapped. An access against that direction raises a one-cycle access-error pulse. A write refused because of the lock raises a separate one-cycle lock-error pulse.

The stored registers cover the PLL control and configuration words, a peripheral reset control word, a reset-reason word and a parameterised bank of pin-function words. The status words (PLL status, boot mode, ID code, memory-controller command and interface status) are constants. The lock status is read-only. Setting bit 0 of the peripheral reset control word while unlocked produces a one-cycle system reset request. The address port carries word indices, so the word index is the byte offset divided by 4.

Top module: `syscfg_ctrl`

## Requirements
- R1: After reset the block is locked. The lock status word at word 0x003 (byte 0x00C) reads 1. The three PLL control words at bytes 0x100/0x104/0x108 read 0x0001A008, PLL status at 0x10C reads 0x0000003F, the three PLL configuration words at 0x110/0x114/0x118 read 0x00014000, reset reason at 0x250 reads 0x00000040 and boot mode at 0x25C reads 0x00000001.
- R2: A write to byte 0x008 (word 0x002) clears the lock when write data bits [15:0] equal 0xDF0D, whatever bits [31:16] hold. Any other value leaves the lock state unchanged and raises no error.
- R3: A write to byte 0x004 (word 0x001) sets the lock when data bits [15:0] equal 0x767B. Any other value leaves the lock state unchanged.
- R4: The lock status word at byte 0x00C reads {31'b0, locked} and is read-only. A write to it pulses acc_err_o and does not change the lock.
- R5: The word at byte 0x000 can be written while locked. It stores only data bit 0, reads back as {31'b0, bit0} and raises no error.
- R6: While locked, a write to any read-write word other than byte 0x000, or to a write-only command word, is discarded and pulses lock_err_o for one cycle.
- R7: A read of a write-only word (bytes 0x004, 0x008, 0x60C, 0x614) pulses acc_err_o and returns 0.
- R8: A write to a read-only word pulses acc_err_o and changes nothing. The read-only words are PLL status 0x10C = 0x3F, boot mode 0x25C = 1, ID code 0x530 = parameter ID_VALUE, command status 0x618 = 0 and interface status 0x620 = 0.
- R9: An unlocked write to byte 0x200 with data bit 0 set drives srst_req_o high for exactly the one cycle after the write. The stored bit reads back as written. A write with bit 0 clear, or any locked write, makes no request.
- R10: There are MUX_N pin-function words starting at byte 0x700. Entries 2 to 8 reset to 0x00000601 and all the others to 0x00001601. They can be read and written when unlocked.
- R11: Unmapped words read 0, ignore writes and pulse acc_err_o on either access.
- R12: Read data and error flags are registered. They appear in the cycle after the strobe. rdata_o holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 10 | Word index (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| acc_err_o | output | 1 | One-cycle pulse: wrong-direction or unmapped access |
| lock_err_o | output | 1 | One-cycle pulse: write refused while locked |
| srst_req_o | output | 1 | One-cycle system reset request |

## Verification
A wrong lock state shows up on the first write that follows: a refused write raises lock_err_o one cycle later, or an accepted write changes a value that the next read exposes, so the bench reads every protected word back after each key sequence. A wrong reset image or a corrupted stored word appears in rdata_o one cycle after the read strobe. A wrong direction entry in the decode shows up as a missing or extra acc_err_o pulse in the cycle after the access. A soft-reset request that is stuck or doubled is caught by sampling srst_req_o in the two cycles that follow the triggering write.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;

    localparam int unsigned DW = 32;
    localparam int unsigned AW = 10;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RW   = 2'd1,
        ACC_RO   = 2'd2,
        ACC_WO   = 2'd3
    } acc_e;

    // word indices (byte offset / 4)
    localparam logic [AW-1:0] W_SCRATCH = 10'h000;
    localparam logic [AW-1:0] W_LOCK    = 10'h001;
    localparam logic [AW-1:0] W_UNLOCK  = 10'h002;
    localparam logic [AW-1:0] W_LKSTAT  = 10'h003;
    localparam logic [AW-1:0] W_PLLC0   = 10'h040;
    localparam logic [AW-1:0] W_PLLC1   = 10'h041;
    localparam logic [AW-1:0] W_PLLC2   = 10'h042;
    localparam logic [AW-1:0] W_PLLSTAT = 10'h043;
    localparam logic [AW-1:0] W_PLLG0   = 10'h044;
    localparam logic [AW-1:0] W_PLLG1   = 10'h045;
    localparam logic [AW-1:0] W_PLLG2   = 10'h046;
    localparam logic [AW-1:0] W_PRST    = 10'h080;
    localparam logic [AW-1:0] W_RSTWHY  = 10'h094;
    localparam logic [AW-1:0] W_BOOT    = 10'h097;
    localparam logic [AW-1:0] W_IDCODE  = 10'h14C;
    localparam logic [AW-1:0] W_DDRCAL  = 10'h183;
    localparam logic [AW-1:0] W_DDRREF  = 10'h185;
    localparam logic [AW-1:0] W_DDRCMD  = 10'h186;
    localparam logic [AW-1:0] W_DFISTAT = 10'h188;
    localparam logic [AW-1:0] W_MUX0    = 10'h1C0;

    localparam logic [15:0] KEY_LOCK   = 16'h767B;
    localparam logic [15:0] KEY_UNLOCK = 16'hDF0D;

    // storage slot numbering
    localparam int unsigned SLOT_SCRATCH = 0;
    localparam int unsigned SLOT_PLLC0   = 1;
    localparam int unsigned SLOT_PLLG0   = 4;
    localparam int unsigned SLOT_PRST    = 7;
    localparam int unsigned SLOT_RSTWHY  = 8;
    localparam int unsigned SLOT_MUX0    = 9;

    localparam logic [DW-1:0] RV_PLLCTRL = 32'h0001_A008;
    localparam logic [DW-1:0] RV_PLLSTAT = 32'h0000_003F;
    localparam logic [DW-1:0] RV_PLLCFG  = 32'h0001_4000;
    localparam logic [DW-1:0] RV_RSTWHY  = 32'h0000_0040;
    localparam logic [DW-1:0] RV_BOOT    = 32'h0000_0001;
    localparam logic [DW-1:0] RV_MUX     = 32'h0000_1601;
    localparam logic [DW-1:0] RV_MUX_LOW = 32'h0000_0601;
    localparam int unsigned   MUX_LOW_FIRST = 2;
    localparam int unsigned   MUX_LOW_LAST  = 8;

endpackage

// File: rtl/syscfg_decode.sv
module syscfg_decode
    import syscfg_pkg::*;
#(
    parameter int unsigned    MUX_N    = 54,
    parameter logic [DW-1:0]  ID_VALUE = 32'h1B2D_3C4F,
    localparam int unsigned   NSLOT    = SLOT_MUX0 + MUX_N,
    localparam int unsigned   SW       = $clog2(NSLOT)
) (
    input  logic [AW-1:0] addr_i,
    input  logic          locked_i,
    output acc_e          acc_o,
    output logic          hit_o,
    output logic [SW-1:0] slot_o,
    output logic [DW-1:0] ro_val_o,
    output logic          is_lock_o,
    output logic          is_unlock_o,
    output logic          is_scratch_o,
    output logic          is_prst_o
);

    localparam int MUX_BASE = int'(W_MUX0);

    logic in_mux;

    always_comb begin
        in_mux = (int'(addr_i) >= MUX_BASE) && (int'(addr_i) < MUX_BASE + int'(MUX_N));
    end

    always_comb begin
        acc_o    = ACC_NONE;
        hit_o    = 1'b0;
        slot_o   = '0;
        ro_val_o = '0;
        if (in_mux) begin
            acc_o  = ACC_RW;
            hit_o  = 1'b1;
            slot_o = SW'(int'(addr_i) - MUX_BASE + int'(SLOT_MUX0));
        end else begin
            unique case (addr_i)
                W_SCRATCH: begin acc_o = ACC_RW; hit_o = 1'b1; slot_o = SW'(SLOT_SCRATCH); end
                W_PLLC0:   begin acc_o = ACC_RW; hit_o = 1'b1; slot_o = SW'(SLOT_PLLC0); end
                W_PLLC1:   begin acc_o = ACC_RW; hit_o = 1'b1; slot_o = SW'(SLOT_PLLC0 + 1); end
                W_PLLC2:   begin acc_o = ACC_RW; hit_o = 1'b1; slot_o = SW'(SLOT_PLLC0 + 2); end
                W_PLLG0:   begin acc_o = ACC_RW; hit_o = 1'b1; slot_o = SW'(SLOT_PLLG0); end
                W_PLLG1:   begin acc_o = ACC_RW; hit_o = 1'b1; slot_o = SW'(SLOT_PLLG0 + 1); end
                W_PLLG2:   begin acc_o = ACC_RW; hit_o = 1'b1; slot_o = SW'(SLOT_PLLG0 + 2); end
                W_PRST:    begin acc_o = ACC_RW; hit_o = 1'b1; slot_o = SW'(SLOT_PRST); end
                W_RSTWHY:  begin acc_o = ACC_RW; hit_o = 1'b1; slot_o = SW'(SLOT_RSTWHY); end
                W_LOCK, W_UNLOCK, W_DDRCAL, W_DDRREF: acc_o = ACC_WO;
                W_LKSTAT:  begin acc_o = ACC_RO; ro_val_o = {{(DW-1){1'b0}}, locked_i}; end
                W_PLLSTAT: begin acc_o = ACC_RO; ro_val_o = RV_PLLSTAT; end
                W_BOOT:    begin acc_o = ACC_RO; ro_val_o = RV_BOOT; end
                W_IDCODE:  begin acc_o = ACC_RO; ro_val_o = ID_VALUE; end
                W_DDRCMD, W_DFISTAT: acc_o = ACC_RO;
                default:   acc_o = ACC_NONE;
            endcase
        end
    end

    always_comb begin
        is_lock_o    = (addr_i == W_LOCK);
        is_unlock_o  = (addr_i == W_UNLOCK);
        is_scratch_o = (addr_i == W_SCRATCH);
        is_prst_o    = (addr_i == W_PRST);
    end

endmodule

// File: rtl/syscfg_lock.sv
module syscfg_lock
    import syscfg_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_i,
    input  logic        is_lock_i,
    input  logic        is_unlock_i,
    input  logic [15:0] key_i,
    output logic        locked_o
);

    typedef struct packed {
        logic locked;
    } lock_t;

    lock_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i && is_lock_i && (key_i == KEY_LOCK)) begin
            st_d.locked = 1'b1;
        end else if (wr_i && is_unlock_i && (key_i == KEY_UNLOCK)) begin
            st_d.locked = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.locked <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked_o = st_q.locked;

endmodule

// File: rtl/syscfg_regfile.sv
module syscfg_regfile
    import syscfg_pkg::*;
#(
    parameter int unsigned  MUX_N = 54,
    localparam int unsigned NSLOT = SLOT_MUX0 + MUX_N,
    localparam int unsigned SW    = $clog2(NSLOT)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [SW-1:0] wslot_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [SW-1:0] rslot_i,
    output logic [DW-1:0] rdata_o
);

    function automatic logic [DW-1:0] init_val(int unsigned s);
        int unsigned m;
        if (s >= SLOT_MUX0) begin
            m = s - SLOT_MUX0;
            return (m >= MUX_LOW_FIRST && m <= MUX_LOW_LAST) ? RV_MUX_LOW : RV_MUX;
        end
        if (s >= SLOT_PLLC0 && s < SLOT_PLLC0 + 3) return RV_PLLCTRL;
        if (s >= SLOT_PLLG0 && s < SLOT_PLLG0 + 3) return RV_PLLCFG;
        if (s == SLOT_RSTWHY) return RV_RSTWHY;
        return '0;
    endfunction

    logic [NSLOT-1:0][DW-1:0] rd_arr;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam logic [DW-1:0] RST_VAL = init_val(g);
        logic [DW-1:0] val_d, val_q;
        logic          sel;

        assign sel = we_i && (wslot_i == SW'(g));

        if (g == SLOT_SCRATCH) begin : g_bit
            always_comb begin
                val_d = val_q;
                if (sel) val_d = {{(DW-1){1'b0}}, wdata_i[0]};
            end
        end else begin : g_word
            always_comb begin
                val_d = val_q;
                if (sel) val_d = wdata_i;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) val_q <= RST_VAL;
            else         val_q <= val_d;
        end

        assign rd_arr[g] = val_q;
    end

    always_comb begin
        rdata_o = '0;
        if (int'(rslot_i) < int'(NSLOT)) rdata_o = rd_arr[rslot_i];
    end

endmodule

// File: rtl/syscfg_ctrl.sv
module syscfg_ctrl
    import syscfg_pkg::*;
#(
    parameter int unsigned   MUX_N    = 54,
    parameter logic [31:0]   ID_VALUE = 32'h1B2D_3C4F
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        rd_en_i,
    input  logic        wr_en_i,
    input  logic [9:0]  addr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        acc_err_o,
    output logic        lock_err_o,
    output logic        srst_req_o
);

    localparam int unsigned NSLOT = SLOT_MUX0 + MUX_N;
    localparam int unsigned SW    = $clog2(NSLOT);

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          acc_err;
        logic          lock_err;
        logic          srst;
    } out_t;

    out_t st_d, st_q;

    acc_e          acc;
    logic          hit;
    logic [SW-1:0] slot;
    logic [DW-1:0] ro_val;
    logic          is_lock, is_unlock, is_scratch, is_prst;
    logic          lock_state;
    logic [DW-1:0] store_rd;

    logic key_wr, wr_dir_bad, wr_refused, store_we, rd_bad;

    syscfg_decode #(.MUX_N(MUX_N), .ID_VALUE(ID_VALUE)) u_dec (
        .addr_i      (addr_i),
        .locked_i    (lock_state),
        .acc_o       (acc),
        .hit_o       (hit),
        .slot_o      (slot),
        .ro_val_o    (ro_val),
        .is_lock_o   (is_lock),
        .is_unlock_o (is_unlock),
        .is_scratch_o(is_scratch),
        .is_prst_o   (is_prst)
    );

    syscfg_lock u_lock (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (wr_en_i),
        .is_lock_i  (is_lock),
        .is_unlock_i(is_unlock),
        .key_i      (wdata_i[15:0]),
        .locked_o   (lock_state)
    );

    syscfg_regfile #(.MUX_N(MUX_N)) u_rf (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (store_we),
        .wslot_i(slot),
        .wdata_i(wdata_i),
        .rslot_i(slot),
        .rdata_o(store_rd)
    );

    always_comb begin
        key_wr     = wr_en_i && (is_lock || is_unlock);
        wr_dir_bad = wr_en_i && (acc == ACC_NONE || acc == ACC_RO);
        wr_refused = wr_en_i && !wr_dir_bad && !key_wr && !is_scratch && lock_state;
        store_we   = wr_en_i && hit && !wr_dir_bad && !(lock_state && !is_scratch);
        rd_bad     = rd_en_i && (acc == ACC_NONE || acc == ACC_WO);
    end

    always_comb begin
        st_d          = st_q;
        st_d.acc_err  = wr_dir_bad || rd_bad;
        st_d.lock_err = wr_refused;
        st_d.srst     = store_we && is_prst && wdata_i[0];
        if (rd_en_i) begin
            if (rd_bad)   st_d.rdata = '0;
            else if (hit) st_d.rdata = store_rd;
            else          st_d.rdata = ro_val;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o    = st_q.rdata;
    assign acc_err_o  = st_q.acc_err;
    assign lock_err_o = st_q.lock_err;
    assign srst_req_o = st_q.srst;

endmodule

// File: rtl/syscfg_chk.sv
module syscfg_chk
    import syscfg_pkg::*;
(
    input logic        clk_i,
    input logic        rst_ni,
    input logic        rd_en_i,
    input logic        wr_en_i,
    input logic [9:0]  addr_i,
    input logic [31:0] wdata_i,
    input logic [31:0] rdata_o,
    input logic        acc_err_o,
    input logic        lock_err_o,
    input logic        srst_req_o,
    input logic        locked_i
);

    logic prst_fire;
    assign prst_fire = wr_en_i && (addr_i == W_PRST) && wdata_i[0] && !locked_i;

    AST_LOCK_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && addr_i == W_LOCK && wdata_i[15:0] == KEY_LOCK |=> locked_i); // R3

    AST_UNLOCK_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && addr_i == W_UNLOCK && wdata_i[15:0] == KEY_UNLOCK |=> !locked_i); // R2

    AST_LOCK_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && (addr_i == W_LOCK || addr_i == W_UNLOCK)) |=> $stable(locked_i)); // R4

    AST_SCRATCH_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && addr_i == W_SCRATCH |=> !lock_err_o && !acc_err_o); // R5

    AST_LOCKED_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && locked_i && addr_i == W_PLLC0 |=> lock_err_o); // R6

    AST_WO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i && addr_i == W_DDRCAL |=> acc_err_o && rdata_o == 32'h0); // R7

    AST_RO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && addr_i == W_BOOT |=> acc_err_o); // R8

    AST_SRST_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prst_fire |=> srst_req_o); // R9

    AST_SRST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst_req_o |-> $past(prst_fire)); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rdata_o)); // R12

endmodule

bind syscfg_ctrl syscfg_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .acc_err_o (acc_err_o),
    .lock_err_o(lock_err_o),
    .srst_req_o(srst_req_o),
    .locked_i  (lock_state)
);

// File: tb/sim_syscfg_ctrl.sv
`timescale 1ns/1ps
module sim_syscfg_ctrl;

    localparam logic [31:0] ID_V = 32'h1B2D_3C4F;

    localparam logic [9:0] A_SCR  = 10'h000, A_LK = 10'h001, A_UL = 10'h002, A_STAT = 10'h003;
    localparam logic [9:0] A_PC0  = 10'h040, A_PST = 10'h043, A_PG0 = 10'h044;
    localparam logic [9:0] A_PRST = 10'h080, A_WHY = 10'h094, A_BOOT = 10'h097;
    localparam logic [9:0] A_ID   = 10'h14C, A_CAL = 10'h183, A_REF = 10'h185;
    localparam logic [9:0] A_CMD  = 10'h186, A_DFI = 10'h188, A_MUX = 10'h1C0, A_HOLE = 10'h3FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        acc_err, lock_err, srst_req;

    int n_chk = 0;
    int n_err = 0;
    logic s_acc, s_lock, s_srst;
    logic [31:0] s_rd;

    always #4 clk = ~clk;

    syscfg_ctrl #(.MUX_N(54), .ID_VALUE(ID_V)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .acc_err_o(acc_err), .lock_err_o(lock_err), .srst_req_o(srst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        s_acc = acc_err; s_lock = lock_err; s_srst = srst_req;
    endtask

    task automatic rd(input logic [9:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        s_rd = rdata; s_acc = acc_err;
    endtask

    task automatic t_reset;
        rd(A_STAT); chk("R1 lock status after reset", s_rd, 32'h1);
        for (int i = 0; i < 3; i++) begin
            rd(A_PC0 + 10'(i)); chk("R1 pll ctrl reset", s_rd, 32'h0001_A008);
            rd(A_PG0 + 10'(i)); chk("R1 pll cfg reset", s_rd, 32'h0001_4000);
        end
        rd(A_PST);  chk("R1 pll status", s_rd, 32'h3F);
        rd(A_WHY);  chk("R1 reset reason", s_rd, 32'h40);
        rd(A_BOOT); chk("R1 boot mode", s_rd, 32'h1);
        chk("R1 outputs idle", {29'b0, acc_err, lock_err, srst_req}, 32'h0);
    endtask

    task automatic t_mux_reset;
        for (int i = 0; i < 54; i++) begin
            rd(A_MUX + 10'(i));
            chk("R10 pin word reset", s_rd, (i >= 2 && i <= 8) ? 32'h0601 : 32'h1601);
        end
    endtask

    task automatic t_scratch;
        wr(A_SCR, 32'hFFFF_FFFF);
        chk("R5 scratch locked write no error", {30'b0, s_acc, s_lock}, 32'h0);
        rd(A_SCR); chk("R5 scratch bit0 only", s_rd, 32'h1);
        wr(A_SCR, 32'h8000_0002);
        rd(A_SCR); chk("R5 scratch cleared", s_rd, 32'h0);
    endtask

    task automatic t_locked;
        wr(A_PC0, 32'h1234_5678);
        chk("R6 locked write lock_err", {31'b0, s_lock}, 32'h1);
        chk("R6 locked write no acc_err", {31'b0, s_acc}, 32'h0);
        @(negedge clk); chk("R6 lock_err one cycle", {31'b0, lock_err}, 32'h0);
        rd(A_PC0); chk("R6 value kept", s_rd, 32'h0001_A008);
        wr(A_CAL, 32'h1); chk("R6 locked command write refused", {31'b0, s_lock}, 32'h1);
    endtask

    task automatic t_keys;
        wr(A_UL, 32'h0000_DF0E);
        chk("R2 wrong key no error", {30'b0, s_acc, s_lock}, 32'h0);
        rd(A_STAT); chk("R2 wrong key stays locked", s_rd, 32'h1);
        wr(A_UL, 32'hABCD_DF0D);
        rd(A_STAT); chk("R2 unlocked, upper bits ignored", s_rd, 32'h0);
        wr(A_PC0, 32'hCAFE_0001);
        chk("R2 unlocked write accepted", {30'b0, s_acc, s_lock}, 32'h0);
        rd(A_PC0); chk("R2 unlocked write stored", s_rd, 32'hCAFE_0001);
        wr(A_LK, 32'h0000_767A);
        rd(A_STAT); chk("R3 wrong lock key ignored", s_rd, 32'h0);
        wr(A_LK, 32'h5555_767B);
        rd(A_STAT); chk("R3 relocked", s_rd, 32'h1);
        wr(A_PC0, 32'h0);
        rd(A_PC0); chk("R3 write after relock refused", s_rd, 32'hCAFE_0001);
    endtask

    task automatic t_ro;
        wr(A_STAT, 32'h0); chk("R4 status write acc_err", {31'b0, s_acc}, 32'h1);
        rd(A_STAT); chk("R4 status unchanged", s_rd, 32'h1);
        wr(A_UL, 32'h0000_DF0D);
        wr(A_BOOT, 32'h7); chk("R8 boot write acc_err", {31'b0, s_acc}, 32'h1);
        rd(A_BOOT); chk("R8 boot unchanged", s_rd, 32'h1);
        wr(A_PST, 32'h0); chk("R8 pll status write acc_err", {31'b0, s_acc}, 32'h1);
        rd(A_PST); chk("R8 pll status unchanged", s_rd, 32'h3F);
        rd(A_ID);  chk("R8 id code", s_rd, ID_V);
        chk("R8 id read no error", {31'b0, s_acc}, 32'h0);
        rd(A_CMD); chk("R8 cmd status zero", s_rd, 32'h0);
        rd(A_DFI); chk("R8 dfi status zero", s_rd, 32'h0);
        chk("R8 status read no error", {31'b0, s_acc}, 32'h0);
    endtask

    task automatic t_wo;
        logic [9:0] wo [4] = '{A_LK, A_UL, A_CAL, A_REF};
        rd(A_PG0);
        for (int i = 0; i < 4; i++) begin
            rd(wo[i]);
            chk("R7 write-only read acc_err", {31'b0, s_acc}, 32'h1);
            chk("R7 write-only read zero", s_rd, 32'h0);
        end
        wr(A_CAL, 32'h1); chk("R7 unlocked command write ok", {30'b0, s_acc, s_lock}, 32'h0);
    endtask

    task automatic t_srst;
        wr(A_PRST, 32'h1);
        chk("R9 request pulse", {31'b0, s_srst}, 32'h1);
        @(negedge clk); chk("R9 request one cycle", {31'b0, srst_req}, 32'h0);
        rd(A_PRST); chk("R9 bit reads back", s_rd, 32'h1);
        wr(A_PRST, 32'h0); chk("R9 clear no request", {31'b0, s_srst}, 32'h0);
        rd(A_PRST); chk("R9 cleared", s_rd, 32'h0);
        wr(A_LK, 32'h767B);
        wr(A_PRST, 32'h1); chk("R9 locked no request", {31'b0, s_srst}, 32'h0);
        wr(A_UL, 32'hDF0D);
    endtask

    task automatic t_mux_rw;
        wr(A_MUX + 10'd53, 32'h0000_00A5);
        rd(A_MUX + 10'd53); chk("R10 last pin word write", s_rd, 32'hA5);
        rd(A_MUX + 10'd52); chk("R10 neighbour untouched", s_rd, 32'h1601);
        rd(A_MUX + 10'd54); chk("R11 past pin bank unmapped", {31'b0, s_acc}, 32'h1);
    endtask

    task automatic t_unmapped;
        wr(A_HOLE, 32'hDEAD_BEEF);
        chk("R11 unmapped write acc_err", {30'b0, s_acc, s_lock}, 32'h2);
        rd(A_HOLE);
        chk("R11 unmapped read zero", s_rd, 32'h0);
        chk("R11 unmapped read acc_err", {31'b0, s_acc}, 32'h1);
        @(negedge clk); chk("R11 acc_err one cycle", {31'b0, acc_err}, 32'h0);
    endtask

    task automatic t_hold;
        rd(A_WHY);
        chk("R12 read data", s_rd, 32'h40);
        repeat (3) @(negedge clk);
        chk("R12 held while idle", rdata, 32'h40);
        wr(A_WHY, 32'h77);
        chk("R12 held across write", rdata, 32'h40);
        rd(A_WHY); chk("R12 new value on next read", s_rd, 32'h77);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_mux_reset;
        t_scratch;
        t_locked;
        t_keys;
        t_ro;
        t_wo;
        t_srst;
        t_mux_rw;
        t_unmapped;
        t_hold;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule